// File: doc/BRIEF.md
# SAR ADC single-conversion controller

This block is the digital half of a 10-bit successive-approximation converter. It holds one control/status register and one result register per analog channel. Once a conversion is started, it runs one sample cycle. It then drives a trial code to an external DAC for each bit, from the most significant bit down to the least. In each step it reads one comparator input and keeps or drops the bit under test.

A conversion can be started in three ways: a software write that sets the start bit, a one-cycle pulse on the timer trigger, or a one-cycle pulse on the external trigger. When the conversion finishes, the result is stored for the selected channel, the done flag rises and an interrupt can be raised. Only single-channel single-shot mode converts. The other mode encodings are accepted and then dropped at once, so the controller never hangs.

The control register sits at address 0 and has these fields:

| Bit(s) | Field | Meaning |
|---|---|---|
| 0 | start | Reads 1 while a conversion runs |
| 1 | done | Set when a conversion completes |
| 2 | irq_en | Interrupt enable |
| 4:3 | mode | 0 single, 1 multi, 2 scan, 3 reserved |
| 7:5 | channel | Selected channel |

Channel c's result is read at address 1+c, zero-extended to 16 bits.

Top module: `sar_adc_ctrl`

## Requirements
- R1: In bit step k (k = 0..9), dac_code_o keeps every bit already decided and has bit 9-k set. That bit is cleared at the end of the step if cmp_i = 1, which means the input is below the DAC output. The stored result is the final code, so an ideal comparator yields the input value, including 0 and 1023.
- R2: sample_o is high in the one cycle after the edge that accepts a start. Ten bit cycles follow. The start bit still reads 1 ten edges after the accepting edge, and done reads 1 eleven edges after it.
- R3: A conversion starts when the controller is idle and either a write to address 0 has bit 0 = 1, or tmr_trig_i is high in a cycle, or ext_trig_i is high in a cycle.
- R4: On completion, the result is written only into the result register of the selected channel (address 1+channel). All other result registers keep their values.
- R5: done (bit 1) is set on completion, and irq_o equals done AND irq_en (bit 2).
- R6: The start bit (bit 0) reads 1 for the whole conversion and 0 once it completes. After reset the control register and all results read 0.
- R7: Writing address 0 with bit 0 = 0 during a conversion stops it on that edge. The start bit reads 0 afterwards, and no result or done flag is produced.
- R8: While the start bit is 1, writes to the mode and channel fields are ignored. A write that sets the start bit from idle also loads mode and channel, and that conversion uses the new values.
- R9: done clears only when address 0 is written with bit 1 = 0 after a read (rd_en_i high) of address 0 that returned done = 1. A clearing write without such a read leaves done at 1.
- R10: A trigger pulse or a write that sets the start bit while a conversion runs is ignored. The running conversion keeps its channel and its timing.
- R11: With mode 1 (multi), 2 (scan) or 3, a start is accepted: the start bit reads 1 for one cycle and then 0. No result is stored and done stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (arms clearing of done) |
| addr_i | input | 4 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational from addr_i |
| tmr_trig_i | input | 1 | Timer trigger pulse |
| ext_trig_i | input | 1 | External trigger pulse |
| cmp_i | input | 1 | Comparator: 1 means input below DAC output |
| sample_o | output | 1 | Sample-and-hold strobe |
| dac_code_o | output | 10 | Trial code to the DAC |
| irq_o | output | 1 | Conversion-complete interrupt |

## Verification
The bench targets the two extreme inputs, 0 and 1023. A sequencer that drops the last bit step, or tests bits in the wrong order, stores the wrong code at one of these ends. It checks done and start at the exact edge where completion should land, which catches an off-by-one in the sample or bit count.

Mid-conversion writes and triggers are driven with a different channel and mode. A design that relatches these fields, or restarts on them, stores into the wrong channel or finishes late. The bench also checks three more faults: an abort that still stores a result, a multi or scan start that hangs or converts, and a done flag that clears without a prior read.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_MULTI  = 2'd1,
    MODE_SCAN   = 2'd2,
    MODE_RSVD   = 2'd3
  } conv_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_BIT    = 2'd2,
    ST_REJECT = 2'd3
  } seq_state_e;

  localparam int unsigned FLD_START    = 0;
  localparam int unsigned FLD_DONE     = 1;
  localparam int unsigned FLD_IRQEN    = 2;
  localparam int unsigned FLD_MODE_LSB = 3;
  localparam int unsigned FLD_MODE_W   = 2;
  localparam int unsigned FLD_CHAN_LSB = 5;
endpackage

// File: rtl/sar_adc_ctrl_reg.sv
module sar_adc_ctrl_reg
  import sar_adc_pkg::*;
#(
  parameter int unsigned CH_W   = 3,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctrl_i,
  input  logic              rd_ctrl_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tmr_trig_i,
  input  logic              ext_trig_i,
  input  logic              busy_i,
  input  logic              conv_done_i,
  output logic              go_o,
  output logic              abort_o,
  output logic              single_o,
  output logic [CH_W-1:0]   chan_o,
  output logic [DATA_W-1:0] ctrl_rd_o,
  output logic              irq_o
);
  conv_mode_e        mode_q, mode_nx;
  logic [CH_W-1:0]   chan_q, chan_nx;
  logic              irq_en_q, done_q, seen_q;
  logic              wr_start, any_trig, fld_wr;

  assign wr_start = wr_ctrl_i & wdata_i[FLD_START];
  assign any_trig = wr_start | tmr_trig_i | ext_trig_i;
  assign go_o     = ~busy_i & any_trig;
  assign abort_o  = busy_i & wr_ctrl_i & ~wdata_i[FLD_START];
  // mode/channel only writable when idle; same-cycle start sees new values
  assign fld_wr   = wr_ctrl_i & ~busy_i;
  assign mode_nx  = fld_wr ? conv_mode_e'(wdata_i[FLD_MODE_LSB +: FLD_MODE_W]) : mode_q;
  assign chan_nx  = fld_wr ? wdata_i[FLD_CHAN_LSB +: CH_W] : chan_q;
  assign single_o = (mode_nx == MODE_SINGLE);
  assign chan_o   = chan_q;
  assign irq_o    = done_q & irq_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_SINGLE;
      chan_q   <= '0;
      irq_en_q <= 1'b0;
    end else begin
      mode_q <= mode_nx;
      chan_q <= chan_nx;
      if (wr_ctrl_i) irq_en_q <= wdata_i[FLD_IRQEN];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (conv_done_i) begin
      done_q <= 1'b1;
    end else if (wr_ctrl_i && !wdata_i[FLD_DONE] && seen_q) begin
      done_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (rd_ctrl_i && done_q) begin
      seen_q <= 1'b1;
    end
  end

  always_comb begin
    ctrl_rd_o                                = '0;
    ctrl_rd_o[FLD_START]                     = busy_i;
    ctrl_rd_o[FLD_DONE]                      = done_q;
    ctrl_rd_o[FLD_IRQEN]                     = irq_en_q;
    ctrl_rd_o[FLD_MODE_LSB +: FLD_MODE_W]    = mode_q;
    ctrl_rd_o[FLD_CHAN_LSB +: CH_W]          = chan_q;
  end

  // R8
  fld_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> ($stable(chan_q) && $stable(mode_q)));
  // R5
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(conv_done_i));
  // R9
  done_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_q) |-> ($past(seen_q) && $past(wr_ctrl_i)));
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_adc_pkg::*;
#(
  parameter int unsigned RES = 10
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           go_i,
  input  logic           single_i,
  input  logic           abort_i,
  input  logic           cmp_i,
  output logic           busy_o,
  output logic           sample_o,
  output logic [RES-1:0] dac_code_o,
  output logic           done_o,
  output logic [RES-1:0] result_o
);
  localparam logic [RES-1:0] TOP_BIT = {1'b1, {(RES-1){1'b0}}};

  seq_state_e     state_q;
  logic [RES-1:0] mask_q, trial_q, trial_dec;
  logic           last_bit;

  assign trial_dec  = cmp_i ? (trial_q & ~mask_q) : trial_q;
  assign last_bit   = mask_q[0];
  assign busy_o     = (state_q != ST_IDLE);
  assign sample_o   = (state_q == ST_SAMPLE);
  assign dac_code_o = trial_q;
  assign done_o     = (state_q == ST_BIT) & last_bit & ~abort_i;
  assign result_o   = trial_dec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      trial_q <= '0;
    end else if (busy_o && abort_i) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      trial_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (go_i) state_q <= single_i ? ST_SAMPLE : ST_REJECT;
        ST_SAMPLE: begin
          state_q <= ST_BIT;
          mask_q  <= TOP_BIT;
          trial_q <= TOP_BIT;
        end
        ST_BIT: begin
          if (last_bit) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
            trial_q <= '0;
          end else begin
            mask_q  <= mask_q >> 1;
            trial_q <= trial_dec | (mask_q >> 1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // cycle counter for the length check only
  logic [7:0] conv_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          conv_cnt <= '0;
    else if (go_i && state_q == ST_IDLE)  conv_cnt <= '0;
    else if (busy_o)                      conv_cnt <= conv_cnt + 8'd1;
  end

  // R2
  conv_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (conv_cnt == 8'(RES)));
  // R1
  trial_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BIT) |-> ($onehot(mask_q) && ((trial_q & mask_q) != '0)));
  // R11
  reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REJECT) |=> (state_q == ST_IDLE));
  // R10
  go_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> (state_q == ST_IDLE));
  // R7
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (state_q == ST_IDLE));
endmodule

// File: rtl/sar_adc_result_bank.sv
module sar_adc_result_bank #(
  parameter int unsigned N_CH = 8,
  parameter int unsigned RES  = 10,
  parameter int unsigned CH_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [CH_W-1:0] chan_i,
  input  logic [RES-1:0]  data_i,
  input  logic [CH_W-1:0] rd_sel_i,
  output logic [RES-1:0]  rd_data_o
);
  logic [RES-1:0] res_q [N_CH];

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            res_q[g] <= '0;
      else if (we_i && chan_i == CH_W'(g))    res_q[g] <= data_i;
    end
    // R4
    keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && chan_i == CH_W'(g)) |=> $stable(res_q[g]));
  end

  assign rd_data_o = (32'(rd_sel_i) < N_CH) ? res_q[rd_sel_i] : '0;
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int unsigned RES    = 10,
  parameter int unsigned N_CH   = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tmr_trig_i,
  input  logic              ext_trig_i,
  input  logic              cmp_i,
  output logic              sample_o,
  output logic [RES-1:0]    dac_code_o,
  output logic              irq_o
);
  localparam int unsigned CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic              ctrl_sel, res_sel;
  logic [CH_W-1:0]   rd_idx, chan;
  logic              go, abort, single, busy, conv_done;
  logic [RES-1:0]    result, res_rd;
  logic [DATA_W-1:0] ctrl_rd;

  assign ctrl_sel = (addr_i == '0);
  assign res_sel  = (32'(addr_i) >= 1) && (32'(addr_i) <= N_CH);
  assign rd_idx   = CH_W'(addr_i - ADDR_W'(1));

  sar_adc_ctrl_reg #(.CH_W(CH_W), .DATA_W(DATA_W)) u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_ctrl_i  (wr_en_i & ctrl_sel),
    .rd_ctrl_i  (rd_en_i & ctrl_sel),
    .wdata_i    (wdata_i),
    .tmr_trig_i (tmr_trig_i),
    .ext_trig_i (ext_trig_i),
    .busy_i     (busy),
    .conv_done_i(conv_done),
    .go_o       (go),
    .abort_o    (abort),
    .single_o   (single),
    .chan_o     (chan),
    .ctrl_rd_o  (ctrl_rd),
    .irq_o      (irq_o)
  );

  sar_adc_seq #(.RES(RES)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (go),
    .single_i  (single),
    .abort_i   (abort),
    .cmp_i     (cmp_i),
    .busy_o    (busy),
    .sample_o  (sample_o),
    .dac_code_o(dac_code_o),
    .done_o    (conv_done),
    .result_o  (result)
  );

  sar_adc_result_bank #(.N_CH(N_CH), .RES(RES), .CH_W(CH_W)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (conv_done),
    .chan_i   (chan),
    .data_i   (result),
    .rd_sel_i (rd_idx),
    .rd_data_o(res_rd)
  );

  always_comb begin
    if (ctrl_sel)     rdata_o = ctrl_rd;
    else if (res_sel) rdata_o = DATA_W'(res_rd);
    else              rdata_o = '0;
  end
endmodule

// File: tb/sar_adc_ctrl_test.sv
module sar_adc_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        tmr = 1'b0, ext = 1'b0;
  logic        cmp, sample, irq;
  logic [9:0]  dac;
  int          ain = 0;
  int          tests = 0, fails = 0;

  typedef struct { string tag; int val; } item_t;
  item_t exp_q[$];
  int    act_q[$];

  always #4 clk = ~clk;

  // ideal comparator: 1 when input below DAC
  assign cmp = (ain < int'(dac));

  sar_adc_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .tmr_trig_i(tmr), .ext_trig_i(ext), .cmp_i(cmp),
    .sample_o(sample), .dac_code_o(dac), .irq_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    while (exp_q.size() > 0 && act_q.size() > 0) begin
      item_t e;
      int a;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      chk(e.tag, a, e.val);
    end
  end

  function automatic logic [15:0] ctl(input bit st, input bit dn, input bit ie,
                                      input int md, input int ch);
    return {8'h00, 3'(ch), 2'(md), ie, dn, st};
  endfunction

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [15:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic collect(input string tag, input int ch, input int val);
    logic [15:0] d;
    item_t it;
    it.tag = tag; it.val = val;
    exp_q.push_back(it);
    peek(4'(ch + 1), d);
    act_q.push_back(int'(d));
  endtask

  task automatic clr_done(input int ch);
    logic [15:0] d;
    rd(4'd0, d);
    wr(4'd0, ctl(0, 0, 0, 0, ch));
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 reset state
    peek(4'd0, d);
    chk("R6 reset ctrl", int'(d), 0);
    chk("R5 reset irq", int'(irq), 0);
    collect("R6 reset result", 0, 0);

    // software start, ch3, irq enabled
    ain = 'h2A5;
    wr(4'd0, ctl(1, 0, 1, 0, 3));
    chk("R2 sample strobe", int'(sample), 1);
    peek(4'd0, d);
    chk("R6 start during conv", int'(d[0]), 1);
    @(negedge clk); chk("R1 bit9 trial", int'(dac), 'h200);
    @(negedge clk); chk("R1 bit8 trial", int'(dac), 'h300);
    @(negedge clk); chk("R1 bit7 trial", int'(dac), 'h280);
    repeat (7) @(negedge clk);
    peek(4'd0, d);
    chk("R2 start at edge 10", int'(d[0]), 1);
    chk("R2 done at edge 10", int'(d[1]), 0);
    @(negedge clk);
    peek(4'd0, d);
    chk("R6 start cleared", int'(d[0]), 0);
    chk("R2 done at edge 11", int'(d[1]), 1);
    chk("R5 irq raised", int'(irq), 1);
    collect("R1 result ch3", 3, 'h2A5);
    collect("R4 ch2 untouched", 2, 0);

    // R9: clear without prior read is ignored
    wr(4'd0, ctl(0, 0, 1, 0, 3));
    peek(4'd0, d);
    chk("R9 done kept without read", int'(d[1]), 1);
    rd(4'd0, d);
    wr(4'd0, ctl(0, 0, 1, 0, 3));
    peek(4'd0, d);
    chk("R9 done cleared after read", int'(d[1]), 0);
    chk("R5 irq follows done", int'(irq), 0);

    // R3 timer trigger, irq disabled
    ain = 1023;
    wr(4'd0, ctl(0, 0, 0, 0, 5));
    tmr = 1'b1; @(negedge clk); tmr = 1'b0;
    repeat (11) @(negedge clk);
    peek(4'd0, d);
    chk("R3 timer conv done", int'(d[1:0]), 2);
    chk("R5 irq masked", int'(irq), 0);
    collect("R3 result ch5 full scale", 5, 1023);
    clr_done(5);

    // R3 external trigger
    ain = 1;
    wr(4'd0, ctl(0, 0, 0, 0, 0));
    ext = 1'b1; @(negedge clk); ext = 1'b0;
    repeat (11) @(negedge clk);
    peek(4'd0, d);
    chk("R3 ext conv done", int'(d[1]), 1);
    collect("R3 result ch0", 0, 1);
    clr_done(0);

    // R8/R10: writes and triggers during a conversion
    ain = 'h155;
    wr(4'd0, ctl(1, 0, 0, 0, 1));
    repeat (3) @(negedge clk);
    wr(4'd0, ctl(1, 0, 0, 2, 6));
    tmr = 1'b1; @(negedge clk); tmr = 1'b0;
    ext = 1'b1; @(negedge clk); ext = 1'b0;
    repeat (4) @(negedge clk);
    peek(4'd0, d);
    chk("R10 still running at edge 10", int'(d[1:0]), 1);
    chk("R8 channel kept", int'(d[7:5]), 1);
    chk("R8 mode kept", int'(d[4:3]), 0);
    @(negedge clk);
    peek(4'd0, d);
    chk("R10 done on time", int'(d[1:0]), 2);
    collect("R8 result ch1", 1, 'h155);
    collect("R8 ch6 untouched", 6, 0);
    clr_done(1);

    // R7 abort
    ain = 500;
    wr(4'd0, ctl(1, 0, 0, 0, 2));
    repeat (4) @(negedge clk);
    wr(4'd0, ctl(0, 0, 0, 0, 2));
    peek(4'd0, d);
    chk("R7 start cleared by abort", int'(d[0]), 0);
    repeat (12) @(negedge clk);
    peek(4'd0, d);
    chk("R7 no done after abort", int'(d[1]), 0);
    collect("R7 no result ch2", 2, 0);

    // R11 multi and scan rejected
    ain = 700;
    wr(4'd0, ctl(1, 0, 0, 1, 4));
    peek(4'd0, d);
    chk("R11 multi start accepted", int'(d[0]), 1);
    chk("R8 mode loaded with start", int'(d[4:3]), 1);
    @(negedge clk);
    peek(4'd0, d);
    chk("R11 multi start dropped", int'(d[0]), 0);
    repeat (12) @(negedge clk);
    peek(4'd0, d);
    chk("R11 multi no done", int'(d[1]), 0);
    collect("R11 multi no result", 4, 0);
    wr(4'd0, ctl(1, 0, 0, 2, 7));
    @(negedge clk);
    peek(4'd0, d);
    chk("R11 scan start dropped", int'(d[0]), 0);
    repeat (12) @(negedge clk);
    peek(4'd0, d);
    chk("R11 scan no done", int'(d[1]), 0);
    collect("R11 scan no result", 7, 0);

    // R1 zero input overwrites ch3
    ain = 0;
    wr(4'd0, ctl(1, 0, 0, 0, 3));
    repeat (11) @(negedge clk);
    peek(4'd0, d);
    chk("R2 zero conv done", int'(d[1]), 1);
    collect("R1 result ch3 zero", 3, 0);

    repeat (5) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule